// File: doc/BRIEF.md
# Multiply-Add/Accumulate Output Stage

This block sits behind a group of hardware multipliers and turns their products into either pairwise sums/differences or running totals. Products arrive on one flat input bus. Each first-level lane takes the product pair `2k` and `2k+1`. The multipliers themselves lie outside the block.

In adder mode (`accum_i` low), lane `k` registers the sum or difference of its two products. The difference is `p(2k) - p(2k+1)`. In accumulate mode (`accum_i` high), lane `k` adds its first product `p(2k)` to its own register, or subtracts it. The second product of the pair is ignored. A synchronous load can replace the total with the product. Each lane raises a per-cycle flag when its total leaves the representable range.

A registered summation stage adds neighbouring lane results. With the wide operand setting this gives one total of four products. With the narrow setting it gives two totals of four products each.

The add/subtract, signedness and load controls each pass through their own delay line of 0, 1 or 2 stages. This lets them arrive aligned with a deeper multiplier pipeline. The data path has no valid/ready handshake. `en_i` is the only flow control: when it is low every register, including the control delay stages, stalls.

Top module: `mac_out_stage`

## Requirements
- R1: In adder mode, a product pair presented at a clock edge where `en_i` is high appears on its lane of `res_o` after that edge. The value is `ext(p(2k)) + ext(p(2k+1))` when the lane's add control is 1, and `ext(p(2k)) - ext(p(2k+1))` when it is 0. The result is taken modulo 2^ACCW.
- R2: Lanes `0 .. NADD/2-1` (the upper lanes) are governed by `addsub_i[1]` and `sload_i[1]`. Lanes `NADD/2 .. NADD-1` are governed by `addsub_i[0]` and `sload_i[0]`. The wide setting has 2 lanes and the narrow setting has 4.
- R3: A control value takes effect DLY enabled edges after it is sampled. DLY is `DLY_ADDSUB`, `DLY_SIGN` or `DLY_SLOAD` (0, 1 or 2), set separately for each kind of control. A cleared delay stage yields 0, which means subtract, unsigned and no load.
- R4: A product is treated as signed when the delayed `sign_a_i | sign_b_i` is 1. A signed product is sign-extended from PRODW to ACCW bits; otherwise it is zero-extended.
- R5: In accumulate mode, lane `k` becomes `res + ext(p(2k))` when its add control is 1, or `res - ext(p(2k))` when it is 0. Product `p(2k+1)` has no effect.
- R6: In accumulate mode, a delayed load bit of 1 makes the lane take `ext(p(2k))` in place of the running total.
- R7: `ovf_o[k]` is registered and describes only the latest update. It is 1 when an accumulate step is not a load and the step overflows. In signed mode this is two's-complement overflow or underflow; in unsigned mode it is a carry out on add or a borrow on subtract. It is 0 after any adder-mode or load step.
- R8: Summation output `j` equals `res(2j) + res(2j+1)` modulo 2^ACCW, one enabled edge after those lane values. The wide setting has one such output and the narrow setting has two; output 0 covers products 0 to 3.
- R9: While `en_i` is low and `clr_i` is low, `res_o`, `ovf_o`, `sum_o` and every control delay stage hold their values.
- R10: `clr_i` high zeroes every register at the next edge, whatever `en_i` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| clr_i | input | 1 | Synchronous active-high clear of all registers |
| en_i | input | 1 | Clock enable for every register |
| accum_i | input | 1 | 1 = accumulate mode, 0 = adder mode |
| addsub_i | input | 2 | Add (1) / subtract (0) controls, upper lanes on bit 1 |
| sign_a_i | input | 1 | Operand A signedness |
| sign_b_i | input | 1 | Operand B signedness |
| sload_i | input | 2 | Accumulator load controls, upper lanes on bit 1 |
| prod_i | input | NPROD*PRODW (144) | Products, product i at bits i*PRODW |
| res_o | output | NADD*ACCW (104) | Lane results, lane k at bits k*ACCW |
| ovf_o | output | NADD (2) | Per-lane overflow/underflow flag |
| sum_o | output | NSUM*ACCW (52) | Summation outputs |

## Verification
On every cycle, assertions confirm several properties. Stalled lanes, sums and delay stages stay unchanged, and clear forces zero. An unsigned accumulating add flags exactly when the total wraps below its old value. A signed add of a positive product flags exactly when the sign bit turns from 0 to 1. The flag stays low after adder-mode and load steps.

Some behaviours only the bench scenarios can show. These are the alignment of each control with its own delay depth and the lane-to-control mapping in both width settings. Others are a load in the middle of a running total, and the long climbs that force signed overflow, signed underflow, unsigned borrow and unsigned carry.

// File: rtl/mac_pkg.sv
package mac_pkg;
  // Control bit that governs lane k of nadd lanes: upper half uses bit 1.
  function automatic int unsigned ctl_bit(input int unsigned k, input int unsigned nadd);
    return (k < nadd / 2) ? 1 : 0;
  endfunction

  // Guard bits added above a product to form the accumulator width.
  localparam int unsigned GUARD_DEFAULT = 16;
endpackage

// File: rtl/mac_ctl_delay.sv
module mac_ctl_delay #(
  parameter int unsigned W     = 2,
  parameter int unsigned DEPTH = 0
) (
  input  logic         clk_i,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign q_o = d_i;
    end else begin : g_stages
      logic [W-1:0] stg [DEPTH];

      always_ff @(posedge clk_i) begin
        if (clr_i) begin
          for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else if (en_i) begin
          stg[0] <= d_i;
          for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
      end

      assign q_o = stg[DEPTH-1];

      AST_DLY_HOLD: assert property (@(posedge clk_i) disable iff (clr_i)
        !en_i |=> $stable(q_o)); // R9
      AST_DLY_CLEAR: assert property (@(posedge clk_i)
        clr_i |=> (q_o == '0)); // R10
    end
  endgenerate
endmodule

// File: rtl/mac_lane.sv
module mac_lane #(
  parameter int unsigned PRODW = 36,
  parameter int unsigned ACCW  = 52
) (
  input  logic             clk_i,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             accum_i,
  input  logic             add_i,
  input  logic             sgn_i,
  input  logic             sload_i,
  input  logic [PRODW-1:0] pa_i,
  input  logic [PRODW-1:0] pb_i,
  output logic [ACCW-1:0]  res_o,
  output logic             ovf_o
);
  localparam int unsigned GW  = ACCW - PRODW;
  localparam int unsigned MSB = ACCW - 1;

  logic [ACCW-1:0] ea, eb, op_a, op_b, nxt;
  logic [ACCW:0]   wide;
  logic            sov, ovf_n;

  assign ea = {{GW{sgn_i & pa_i[PRODW-1]}}, pa_i};
  assign eb = {{GW{sgn_i & pb_i[PRODW-1]}}, pb_i};

  // Accumulate mode feeds the lane register back as the first operand.
  assign op_a = accum_i ? res_o : ea;
  assign op_b = accum_i ? ea : eb;

  always_comb begin
    if (add_i) begin
      wide = {1'b0, op_a} + {1'b0, op_b};
      sov  = (op_a[MSB] == op_b[MSB]) && (wide[MSB] != op_a[MSB]);
    end else begin
      wide = {1'b0, op_a} - {1'b0, op_b};
      sov  = (op_a[MSB] != op_b[MSB]) && (wide[MSB] != op_a[MSB]);
    end
    nxt   = (accum_i && sload_i) ? ea : wide[ACCW-1:0];
    ovf_n = accum_i && !sload_i && (sgn_i ? sov : wide[ACCW]);
  end

  always_ff @(posedge clk_i) begin
    if (clr_i) begin
      res_o <= '0;
      ovf_o <= 1'b0;
    end else if (en_i) begin
      res_o <= nxt;
      ovf_o <= ovf_n;
    end
  end

  AST_LANE_HOLD: assert property (@(posedge clk_i) disable iff (clr_i)
    !en_i |=> ($stable(res_o) && $stable(ovf_o))); // R9
  AST_LANE_CLEAR: assert property (@(posedge clk_i)
    clr_i |=> (res_o == '0 && !ovf_o)); // R10
  AST_NO_OVF_OUTSIDE_ACC: assert property (@(posedge clk_i) disable iff (clr_i)
    (en_i && !(accum_i && !sload_i)) |=> !ovf_o); // R7
  AST_UNSIGNED_WRAP: assert property (@(posedge clk_i) disable iff (clr_i)
    (en_i && accum_i && !sload_i && !sgn_i && add_i) |=> (ovf_o == (res_o < $past(res_o)))); // R7
  AST_POS_ADD_OVF: assert property (@(posedge clk_i) disable iff (clr_i)
    (en_i && accum_i && !sload_i && sgn_i && add_i && !pa_i[PRODW-1])
      |=> (ovf_o == (!$past(res_o[MSB]) && res_o[MSB]))); // R7
endmodule

// File: rtl/mac_sum.sv
module mac_sum #(
  parameter int unsigned ACCW = 52,
  parameter int unsigned NADD = 2,
  localparam int unsigned NSUM = NADD / 2
) (
  input  logic                 clk_i,
  input  logic                 clr_i,
  input  logic                 en_i,
  input  logic [NADD*ACCW-1:0] res_i,
  output logic [NSUM*ACCW-1:0] sum_o
);
  always_ff @(posedge clk_i) begin
    if (clr_i) begin
      sum_o <= '0;
    end else if (en_i) begin
      for (int j = 0; j < NSUM; j++)
        sum_o[j*ACCW +: ACCW] <= res_i[(2*j)*ACCW +: ACCW] + res_i[(2*j+1)*ACCW +: ACCW];
    end
  end

  AST_SUM_HOLD: assert property (@(posedge clk_i) disable iff (clr_i)
    !en_i |=> $stable(sum_o)); // R9
  AST_SUM_CLEAR: assert property (@(posedge clk_i)
    clr_i |=> (sum_o == '0)); // R10
endmodule

// File: rtl/mac_out_stage.sv
module mac_out_stage
  import mac_pkg::*;
#(
  parameter int unsigned WIDE       = 1,
  parameter int unsigned NARROW_OPW = 9,
  parameter int unsigned GUARD      = GUARD_DEFAULT,
  parameter int unsigned DLY_ADDSUB = 0,
  parameter int unsigned DLY_SIGN   = 0,
  parameter int unsigned DLY_SLOAD  = 0,
  parameter int unsigned USE_SUM    = 1,
  localparam int unsigned OPW   = (WIDE != 0) ? 2 * NARROW_OPW : NARROW_OPW,
  localparam int unsigned PRODW = 2 * OPW,
  localparam int unsigned NPROD = (WIDE != 0) ? 4 : 8,
  localparam int unsigned NADD  = NPROD / 2,
  localparam int unsigned NSUM  = NADD / 2,
  localparam int unsigned ACCW  = PRODW + GUARD
) (
  input  logic                   clk_i,
  input  logic                   clr_i,
  input  logic                   en_i,
  input  logic                   accum_i,
  input  logic [1:0]             addsub_i,
  input  logic                   sign_a_i,
  input  logic                   sign_b_i,
  input  logic [1:0]             sload_i,
  input  logic [NPROD*PRODW-1:0] prod_i,
  output logic [NADD*ACCW-1:0]   res_o,
  output logic [NADD-1:0]        ovf_o,
  output logic [NSUM*ACCW-1:0]   sum_o
);
  logic [1:0] as_d, sg_d, sl_d;
  logic       sgn;

  mac_ctl_delay #(.W(2), .DEPTH(DLY_ADDSUB)) u_dly_addsub (
    .clk_i(clk_i), .clr_i(clr_i), .en_i(en_i), .d_i(addsub_i), .q_o(as_d));
  mac_ctl_delay #(.W(2), .DEPTH(DLY_SIGN)) u_dly_sign (
    .clk_i(clk_i), .clr_i(clr_i), .en_i(en_i), .d_i({sign_a_i, sign_b_i}), .q_o(sg_d));
  mac_ctl_delay #(.W(2), .DEPTH(DLY_SLOAD)) u_dly_sload (
    .clk_i(clk_i), .clr_i(clr_i), .en_i(en_i), .d_i(sload_i), .q_o(sl_d));

  assign sgn = |sg_d;

  for (genvar k = 0; k < NADD; k++) begin : g_lane
    localparam int unsigned CB = ctl_bit(k, NADD);
    mac_lane #(.PRODW(PRODW), .ACCW(ACCW)) u_lane (
      .clk_i  (clk_i),
      .clr_i  (clr_i),
      .en_i   (en_i),
      .accum_i(accum_i),
      .add_i  (as_d[CB]),
      .sgn_i  (sgn),
      .sload_i(sl_d[CB]),
      .pa_i   (prod_i[(2*k)*PRODW +: PRODW]),
      .pb_i   (prod_i[(2*k+1)*PRODW +: PRODW]),
      .res_o  (res_o[k*ACCW +: ACCW]),
      .ovf_o  (ovf_o[k])
    );
  end

  if (USE_SUM != 0) begin : g_sum
    mac_sum #(.ACCW(ACCW), .NADD(NADD)) u_sum (
      .clk_i(clk_i), .clr_i(clr_i), .en_i(en_i), .res_i(res_o), .sum_o(sum_o));
  end else begin : g_nosum
    assign sum_o = '0;
  end
endmodule

// File: tb/tb_mac_out_stage.sv
module mac_tb_harness #(
  parameter int unsigned WIDE = 1,
  parameter int unsigned DA   = 0,
  parameter int unsigned DS   = 0,
  parameter int unsigned DL   = 0,
  parameter int unsigned SEED = 1
) (
  input  logic clk,
  output logic done,
  output int   checks,
  output int   errors
);
  localparam int unsigned OPW   = (WIDE != 0) ? 18 : 9;
  localparam int unsigned PRODW = 2 * OPW;
  localparam int unsigned NPROD = (WIDE != 0) ? 4 : 8;
  localparam int unsigned NADD  = NPROD / 2;
  localparam int unsigned NSUM  = NADD / 2;
  localparam int unsigned ACCW  = PRODW + 16;

  logic clr, en, accum, sa, sb;
  logic [1:0] addsub, sload;
  logic [NPROD*PRODW-1:0] prod;
  logic [NADD*ACCW-1:0] res;
  logic [NADD-1:0] ovf;
  logic [NSUM*ACCW-1:0] sum;

  mac_out_stage #(.WIDE(WIDE), .DLY_ADDSUB(DA), .DLY_SIGN(DS), .DLY_SLOAD(DL)) dut (
    .clk_i(clk), .clr_i(clr), .en_i(en), .accum_i(accum), .addsub_i(addsub),
    .sign_a_i(sa), .sign_b_i(sb), .sload_i(sload), .prod_i(prod),
    .res_o(res), .ovf_o(ovf), .sum_o(sum));

  logic [ACCW-1:0] m_res [NADD];
  logic            m_ovf [NADD];
  logic [ACCW-1:0] m_sum [NSUM];
  logic [1:0] as_p [2];
  logic [1:0] sl_p [2];
  logic       sg_p [2];
  string tag;

  function automatic logic [ACCW-1:0] ext(input logic [PRODW-1:0] p, input logic s);
    return {{(ACCW-PRODW){s & p[PRODW-1]}}, p};
  endfunction

  function automatic logic [PRODW-1:0] pk(input int i);
    return prod[i*PRODW +: PRODW];
  endfunction

  task automatic chk(input logic ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    logic [1:0] as_e, sl_e;
    logic sg_e, add, ld;
    int cb;
    logic [ACCW-1:0] a, ea, eb, r;
    as_e = (DA == 0) ? addsub : (DA == 1) ? as_p[0] : as_p[1];
    sl_e = (DL == 0) ? sload  : (DL == 1) ? sl_p[0] : sl_p[1];
    sg_e = (DS == 0) ? (sa | sb) : (DS == 1) ? sg_p[0] : sg_p[1];
    if (clr) begin
      for (int k = 0; k < NADD; k++) begin m_res[k] = '0; m_ovf[k] = 1'b0; end
      for (int j = 0; j < NSUM; j++) m_sum[j] = '0;
      for (int i = 0; i < 2; i++) begin as_p[i] = '0; sl_p[i] = '0; sg_p[i] = 1'b0; end
    end else if (en) begin
      for (int j = 0; j < NSUM; j++) m_sum[j] = m_res[2*j] + m_res[2*j+1];
      for (int k = 0; k < NADD; k++) begin
        cb  = (k < NADD / 2) ? 1 : 0;
        add = as_e[cb];
        ld  = sl_e[cb];
        ea  = ext(pk(2*k), sg_e);
        eb  = ext(pk(2*k+1), sg_e);
        if (!accum) begin
          m_res[k] = add ? ea + eb : ea - eb;
          m_ovf[k] = 1'b0;
        end else if (ld) begin
          m_res[k] = ea;
          m_ovf[k] = 1'b0;
        end else begin
          a = m_res[k];
          r = add ? a + ea : a - ea;
          if (sg_e)
            m_ovf[k] = add ? (a[ACCW-1] == ea[ACCW-1] && r[ACCW-1] != a[ACCW-1])
                           : (a[ACCW-1] != ea[ACCW-1] && r[ACCW-1] != a[ACCW-1]);
          else
            m_ovf[k] = add ? (r < a) : (ea > a);
          m_res[k] = r;
        end
      end
      as_p[1] = as_p[0]; as_p[0] = addsub;
      sl_p[1] = sl_p[0]; sl_p[0] = sload;
      sg_p[1] = sg_p[0]; sg_p[0] = sa | sb;
    end
    @(negedge clk);
    for (int k = 0; k < NADD; k++) begin
      chk(res[k*ACCW +: ACCW] == m_res[k], "res lane", 64'(res[k*ACCW +: ACCW]), 64'(m_res[k]));
      chk(ovf[k] == m_ovf[k], "ovf lane", 64'(ovf[k]), 64'(m_ovf[k]));
    end
    for (int j = 0; j < NSUM; j++)
      chk(sum[j*ACCW +: ACCW] == m_sum[j], "sum", 64'(sum[j*ACCW +: ACCW]), 64'(m_sum[j]));
  endtask

  task automatic set_all(input logic [PRODW-1:0] v);
    for (int i = 0; i < NPROD; i++) prod[i*PRODW +: PRODW] = v;
  endtask

  task automatic rnd_prod();
    for (int i = 0; i < NPROD; i++) prod[i*PRODW +: PRODW] = PRODW'({$urandom, $urandom});
  endtask

  task automatic settle();
    set_all('0);
    for (int i = 0; i < 3; i++) step();
  endtask

  initial begin
    logic [ACCW:0] tgt;
    logic [PRODW-1:0] pmax;
    done = 1'b0; checks = 0; errors = 0;
    void'($urandom(SEED));
    clr = 1'b1; en = 1'b1; accum = 1'b0; sa = 1'b0; sb = 1'b0;
    addsub = 2'b00; sload = 2'b00; prod = '0;
    tag = "R10 reset";
    @(negedge clk);
    step(); step();
    clr = 1'b0;

    // R1 R2: fixed controls, upper lanes add, lower lanes subtract, then swapped
    tag = "R1 R2 add/sub mapping";
    addsub = 2'b10; settle();
    for (int i = 0; i < 6; i++) begin rnd_prod(); step(); end
    addsub = 2'b01; settle();
    for (int i = 0; i < 6; i++) begin rnd_prod(); step(); end
    tag = "R4 signed products";
    sa = 1'b1; settle();
    for (int i = 0; i < 6; i++) begin rnd_prod(); step(); end
    sa = 1'b0; sb = 1'b1; addsub = 2'b11; settle();
    for (int i = 0; i < 6; i++) begin rnd_prod(); step(); end

    // R5 R6: accumulation with a load in the middle
    tag = "R5 R6 sload mid accumulation";
    accum = 1'b1; sb = 1'b0; addsub = 2'b11;
    for (int i = 0; i < 8; i++) begin rnd_prod(); step(); end
    sload = 2'b10; rnd_prod(); step();
    sload = 2'b00;
    for (int i = 0; i < 8; i++) begin rnd_prod(); addsub = 2'($urandom); step(); end

    // R1 R2 R3 R4 R5 R6 R8: random controls, delays and enables
    tag = "R3 R8 random R1 R2 R4 R5 R6";
    for (int i = 0; i < 1500; i++) begin
      if (i % 64 == 0) accum = 1'($urandom);
      clr = ($urandom_range(99) == 0);
      en = ($urandom_range(9) != 0);
      addsub = 2'($urandom);
      sa = 1'($urandom); sb = 1'($urandom);
      sload = ($urandom_range(7) == 0) ? 2'($urandom) : 2'b00;
      rnd_prod(); step();
    end
    clr = 1'b0; en = 1'b1;

    // R9: enable low with changing inputs holds everything
    tag = "R9 enable low";
    en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      addsub = 2'($urandom); sload = 2'($urandom); sa = 1'($urandom); rnd_prod(); step();
    end
    en = 1'b1; sload = 2'b00;
    for (int i = 0; i < 4; i++) begin rnd_prod(); step(); end

    // R7: forced unsigned borrow and carry
    tag = "R7 unsigned overflow";
    accum = 1'b1; sa = 1'b0; sb = 1'b0; addsub = 2'b00;
    sload = 2'b11; settle(); sload = 2'b00; settle();
    set_all(PRODW'(1)); step();
    addsub = 2'b11; settle();
    set_all(PRODW'(1)); step();
    settle();

    // R7: signed overflow then signed underflow
    tag = "R7 signed overflow";
    sload = 2'b11; settle(); sload = 2'b00; settle();
    pmax = '1;
    tgt = (ACCW+1)'(1) << (ACCW-1);
    tgt = tgt - ((ACCW+1)'(1) << (PRODW-2));
    set_all(pmax);
    while (({1'b0, m_res[0]} + {{(ACCW+1-PRODW){1'b0}}, pmax}) < tgt) step();
    set_all(PRODW'(tgt - {1'b0, m_res[0]})); step();
    sa = 1'b1; settle();
    set_all((PRODW'(1) << (PRODW-2)) + PRODW'(5)); step();
    addsub = 2'b00; settle();
    tag = "R7 signed underflow";
    set_all(PRODW'(1) << (PRODW-2)); step();
    settle();

    // R10: clear dominates a low enable
    tag = "R10 clear over enable";
    en = 1'b0; clr = 1'b1; step();
    clr = 1'b0; step();
    done = 1'b1;
  end
endmodule

module tb_mac_out_stage;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic d0, d1, d2;
  int c0, c1, c2, e0, e1, e2;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_tb_harness #(.WIDE(1), .DA(0), .DS(0), .DL(0), .SEED(11)) h_wide0 (
    .clk(clk), .done(d0), .checks(c0), .errors(e0));
  mac_tb_harness #(.WIDE(1), .DA(1), .DS(2), .DL(1), .SEED(23)) h_wide1 (
    .clk(clk), .done(d1), .checks(c1), .errors(e1));
  mac_tb_harness #(.WIDE(0), .DA(2), .DS(1), .DL(2), .SEED(37)) h_narrow (
    .clk(clk), .done(d2), .checks(c2), .errors(e2));

  initial begin
    int extra_err;
    extra_err = 0;
    for (int i = 0; i < WATCHDOG; i++) begin
      @(posedge clk);
      if (d0 === 1'b1 && d1 === 1'b1 && d2 === 1'b1) break;
    end
    if (!(d0 === 1'b1 && d1 === 1'b1 && d2 === 1'b1)) begin
      extra_err = 1;
      $display("FAIL watchdog: actual not done, expected done within %0d cycles", WATCHDOG);
    end
    $display("Simulation finished: %0d checks, %0d errors",
             c0 + c1 + c2 + extra_err, e0 + e1 + e2 + extra_err);
    $finish;
  end
endmodule